// File: doc/BRIEF.md
# Stepped Reference Slew Controller

This block drives the code of an internal reference DAC toward a target voltage code. It moves one LSB (one 25 mV step) for each single-cycle slew tick, so the output voltage ramps at a controlled rate instead of jumping. The same ramp serves soft-start, soft-shutdown, changes of the requested code, and entry to or exit from suspend.

The target comes from a selector. In normal operation it is the incoming VID code. A pre-decoded three-level suspend state can replace that code with one of four suspend codes, taken from an upper or a lower range. When the run request is low, the target is zero. While a transition is in progress, and for a fixed number of ticks after the DAC code settles, the block holds the power-good report at its last value and forces the undervoltage fault report low. A busy flag shows when this blanking window is open.

Top module: `ref_slew_ctrl`

## Requirements
- R1: On every cycle with `slew_tick` high, `dac_code` moves exactly one LSB toward the target. It does not change when `slew_tick` is low or when it already equals the target.
- R2: With `run_en` high and `susp_state` = 2'b00, the target is `vid_code`.
- R3: With `run_en` high, `susp_state` = 2'b01 selects the upper suspend range, with target 20 + 2·`susp_sel`. The values 2'b10 and 2'b11 select the lower range, with target 4 + 2·`susp_sel`.
- R4: `offset_en` is high exactly when `susp_state` = 2'b00.
- R5: With `run_en` low the target is 0, so the code ramps down to zero. When `run_en` rises again, the code ramps up from zero to the selected target.
- R6: `busy` rises on the clock after `dac_code` first differs from the target. It falls on the 24th tick counted after `dac_code` equals the target.
- R7: While `busy` is high, `pgood` keeps its value. Once `busy` is low, `pgood` takes `pg_raw` on the next clock.
- R8: While `busy` is high, `uv_fault` is forced low on the following clock. Otherwise `uv_fault` takes `uv_raw` on the next clock.
- R9: If the target changes during a ramp, stepping continues from the present code toward the new target. The 24-tick count starts only once the new target is reached.
- R10: After reset, `dac_code` = 0, `pgood` = 0, `uv_fault` = 0 and `busy` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slew_tick | input | 1 | Single-cycle slew step enable |
| vid_code | input | CODE_W | Requested code in normal operation |
| susp_sel | input | 2 | Picks one of four codes in the suspend range |
| susp_state | input | 2 | Decoded suspend level: 00 normal, 01 upper, 10/11 lower |
| run_en | input | 1 | High: run at the selected target; low: ramp to zero |
| pg_raw | input | 1 | Raw power-good comparator result |
| uv_raw | input | 1 | Raw undervoltage comparator result |
| dac_code | output | CODE_W | Stepped reference code |
| offset_en | output | 1 | Offset amplifier enable |
| pgood | output | 1 | Blanked power-good |
| uv_fault | output | 1 | Masked undervoltage fault |
| busy | output | 1 | Transition or blanking window in progress |

## Verification
The assertions assume that `slew_tick` is a one-cycle pulse in the clock domain. The step and hold properties compare `dac_code` only against its own previous value, so they accept any tick rate. The bench drives each tick for one clock, follows it with one idle clock, and changes all inputs away from the active edge. This keeps every target change visible to the selector for a whole cycle before the next step. The suspend-state value 2'b11 is driven on purpose, to cover the lower-range alias.

// File: rtl/ref_slew_pkg.sv
package ref_slew_pkg;

  typedef enum logic [1:0] {
    SUSP_NONE  = 2'b00,
    SUSP_UPPER = 2'b01,
    SUSP_LOWER = 2'b10,
    SUSP_LOWX  = 2'b11
  } susp_state_e;

  localparam int unsigned SUSP_CODES = 4;

endpackage

// File: rtl/slew_target_sel.sv
module slew_target_sel
  import ref_slew_pkg::*;
#(
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned HI_BASE   = 20,
  parameter int unsigned LO_BASE   = 4,
  parameter int unsigned SUSP_STEP = 2
) (
  input  logic [CODE_W-1:0] vid_code,
  input  logic [1:0]        susp_sel,
  input  logic [1:0]        susp_state,
  input  logic              run_en,
  output logic [CODE_W-1:0] target,
  output logic              offset_en
);

  logic [CODE_W-1:0] hi_tab [SUSP_CODES];
  logic [CODE_W-1:0] lo_tab [SUSP_CODES];

  for (genvar gi = 0; gi < SUSP_CODES; gi++) begin : g_tab
    assign hi_tab[gi] = CODE_W'(HI_BASE + gi * SUSP_STEP);
    assign lo_tab[gi] = CODE_W'(LO_BASE + gi * SUSP_STEP);
  end

  susp_state_e st;
  logic [CODE_W-1:0] sel_code;

  always_comb begin
    st = susp_state_e'(susp_state);
    unique case (st)
      SUSP_NONE:  sel_code = vid_code;
      SUSP_UPPER: sel_code = hi_tab[susp_sel];
      default:    sel_code = lo_tab[susp_sel];
    endcase
    target    = run_en ? sel_code : '0;
    offset_en = (st == SUSP_NONE);
  end

endmodule

// File: rtl/slew_stepper.sv
module slew_stepper #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] target,
  output logic [CODE_W-1:0] code,
  output logic              mismatch
);

  logic [CODE_W-1:0] code_q, code_d;
  logic              step_en;

  always_comb begin
    mismatch = (code_q != target);
    step_en  = tick && mismatch;
    code_d   = code_q;
    if (step_en) begin
      if (target > code_q) code_d = code_q + 1'b1;
      else                 code_d = code_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (step_en) code_q <= code_d;
  end

  assign code = code_q;

endmodule

// File: rtl/slew_blank_timer.sv
module slew_blank_timer #(
  parameter int unsigned BLANK_TICKS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic mismatch,
  input  logic pg_raw,
  input  logic uv_raw,
  output logic busy,
  output logic pgood,
  output logic uv_fault
);

  localparam int unsigned CNT_W = $clog2(BLANK_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLANK_TICKS - 1);

  logic             blank_q, blank_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pg_q, pg_d;
  logic             uv_q, uv_d;
  logic             open;

  always_comb begin
    blank_d = blank_q;
    cnt_d   = cnt_q;
    if (mismatch) begin
      blank_d = 1'b1;
      cnt_d   = '0;
    end else if (blank_q && tick) begin
      if (cnt_q == LAST) begin
        blank_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    open = !blank_q && !mismatch;
    pg_d = open ? pg_raw : pg_q;
    uv_d = open ? uv_raw : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b1;
      cnt_q   <= '0;
      pg_q    <= 1'b0;
      uv_q    <= 1'b0;
    end else begin
      blank_q <= blank_d;
      cnt_q   <= cnt_d;
      pg_q    <= pg_d;
      uv_q    <= uv_d;
    end
  end

  assign busy     = blank_q;
  assign pgood    = pg_q;
  assign uv_fault = uv_q;

endmodule

// File: rtl/ref_slew_ctrl.sv
module ref_slew_ctrl #(
  parameter int unsigned CODE_W      = 5,
  parameter int unsigned BLANK_TICKS = 24,
  parameter int unsigned HI_BASE     = 20,
  parameter int unsigned LO_BASE     = 4,
  parameter int unsigned SUSP_STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slew_tick,
  input  logic [CODE_W-1:0] vid_code,
  input  logic [1:0]        susp_sel,
  input  logic [1:0]        susp_state,
  input  logic              run_en,
  input  logic              pg_raw,
  input  logic              uv_raw,
  output logic [CODE_W-1:0] dac_code,
  output logic              offset_en,
  output logic              pgood,
  output logic              uv_fault,
  output logic              busy
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [CODE_W-1:0] target;
  logic              mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  slew_target_sel #(
    .CODE_W(CODE_W), .HI_BASE(HI_BASE), .LO_BASE(LO_BASE), .SUSP_STEP(SUSP_STEP)
  ) u_sel (
    .vid_code(vid_code), .susp_sel(susp_sel), .susp_state(susp_state),
    .run_en(run_en), .target(target), .offset_en(offset_en)
  );

  slew_stepper #(.CODE_W(CODE_W)) u_step (
    .clk(clk), .rst_n(rst_int_n), .tick(slew_tick), .target(target),
    .code(dac_code), .mismatch(mismatch)
  );

  slew_blank_timer #(.BLANK_TICKS(BLANK_TICKS)) u_blank (
    .clk(clk), .rst_n(rst_int_n), .tick(slew_tick), .mismatch(mismatch),
    .pg_raw(pg_raw), .uv_raw(uv_raw), .busy(busy), .pgood(pgood),
    .uv_fault(uv_fault)
  );

endmodule

// File: rtl/ref_slew_chk.sv
module ref_slew_chk #(
  parameter int unsigned CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slew_tick,
  input logic [CODE_W-1:0] dac_code,
  input logic              pgood,
  input logic              uv_fault,
  input logic              busy
);

  AST_ONE_LSB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |->
      (dac_code == $past(dac_code) + 1'b1 || dac_code == $past(dac_code) - 1'b1)); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !slew_tick |=> $stable(dac_code)); // R1

  AST_MOVE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> busy); // R6

  AST_PG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pgood)); // R7

  AST_UV_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !uv_fault); // R8

endmodule

bind ref_slew_ctrl ref_slew_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slew_tick(slew_tick), .dac_code(dac_code),
  .pgood(pgood), .uv_fault(uv_fault), .busy(busy)
);

// File: tb/ref_slew_ctrl_tb_top.sv
module ref_slew_ctrl_tb_top;

  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          slew_tick;
  logic [CW-1:0] vid_code;
  logic [1:0]    susp_sel;
  logic [1:0]    susp_state;
  logic          run_en;
  logic          pg_raw;
  logic          uv_raw;
  logic [CW-1:0] dac_code;
  logic          offset_en;
  logic          pgood;
  logic          uv_fault;
  logic          busy;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ref_slew_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .slew_tick(slew_tick), .vid_code(vid_code),
    .susp_sel(susp_sel), .susp_state(susp_state), .run_en(run_en),
    .pg_raw(pg_raw), .uv_raw(uv_raw), .dac_code(dac_code),
    .offset_en(offset_en), .pgood(pgood), .uv_fault(uv_fault), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) slew_tick = 1'b1;
    @(negedge clk) slew_tick = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      if (!busy) break;
      pulse();
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; slew_tick = 1'b0; vid_code = 5'd16; susp_sel = 2'd0;
    susp_state = 2'b00; run_en = 1'b0; pg_raw = 1'b1; uv_raw = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 dac_code", dac_code, 0);
    chk("R10 pgood", pgood, 0);
    chk("R10 uv_fault", uv_fault, 0);
    chk("R10 busy", busy, 1);
  endtask

  task automatic t_idle_blank();
    repeat (23) pulse();
    chk("R6 busy after 23 ticks", busy, 1);
    chk("R7 pgood frozen", pgood, 0);
    chk("R8 uv masked", uv_fault, 0);
    pulse();
    chk("R6 busy after 24 ticks", busy, 0);
    @(negedge clk);
    chk("R7 pgood follows raw", pgood, 1);
    chk("R8 uv follows raw", uv_fault, 1);
    uv_raw = 1'b0;
    @(negedge clk);
    chk("R8 uv clears", uv_fault, 0);
  endtask

  task automatic t_soft_start();
    run_en = 1'b1; vid_code = 5'd10; pg_raw = 1'b0; uv_raw = 1'b1;
    @(negedge clk);
    chk("R6 busy rises", busy, 1);
    chk("R8 uv masked in ramp", uv_fault, 0);
    for (int i = 1; i <= 10; i++) begin
      pulse();
      chk("R5 ramp up step", dac_code, i);
      chk("R7 pgood held", pgood, 1);
    end
    repeat (3) @(negedge clk);
    chk("R1 no tick no move", dac_code, 10);
    pulse();
    chk("R1 at target no move", dac_code, 10);
    uv_raw = 1'b0;
    settle();
    chk("R7 pgood updates", pgood, 0);
    pg_raw = 1'b1;
    @(negedge clk);
    chk("R7 pgood tracks", pgood, 1);
  endtask

  task automatic t_vid_down();
    vid_code = 5'd7;
    pulse(); chk("R2 step down", dac_code, 9);
    pulse(); chk("R2 step down", dac_code, 8);
    pulse(); chk("R2 reach vid", dac_code, 7);
    settle();
    chk("R2 settled", dac_code, 7);
  endtask

  task automatic t_suspend();
    susp_state = 2'b01; susp_sel = 2'd2;
    @(negedge clk);
    chk("R4 offset off upper", offset_en, 0);
    settle();
    chk("R3 upper sel2", dac_code, 24);
    susp_state = 2'b10; susp_sel = 2'd1;
    settle();
    chk("R3 lower sel1", dac_code, 6);
    susp_state = 2'b11; susp_sel = 2'd3;
    @(negedge clk);
    chk("R4 offset off alias", offset_en, 0);
    settle();
    chk("R3 lower alias sel3", dac_code, 10);
    susp_state = 2'b00;
    @(negedge clk);
    chk("R4 offset on normal", offset_en, 1);
    settle();
    chk("R2 back to vid", dac_code, 7);
  endtask

  task automatic t_retarget();
    vid_code = 5'd20;
    pulse(); pulse(); pulse();
    chk("R9 mid ramp", dac_code, 10);
    vid_code = 5'd8;
    pulse(); chk("R9 turn from present", dac_code, 9);
    pulse(); chk("R9 new target", dac_code, 8);
    repeat (23) pulse();
    chk("R9 count restarted", busy, 1);
    pulse();
    chk("R9 window closed", busy, 0);
  endtask

  task automatic t_shutdown();
    run_en = 1'b0;
    settle();
    chk("R5 shutdown to zero", dac_code, 0);
    run_en = 1'b1; vid_code = 5'd3;
    pulse(); chk("R5 restart from zero", dac_code, 1);
    pulse(); pulse();
    chk("R5 restart reach", dac_code, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_blank();
    t_soft_start();
    t_vid_down();
    t_suspend();
    t_retarget();
    t_shutdown();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule